// File: doc/BRIEF.md
# CPU Frame Injection Framer

This block sits between a processor-facing write port and a switch ingress queue. Software opens a frame with a start control write and supplies the forwarding attributes for that frame: destination port mask, tag kind, VLAN identifier, an analyzer-bypass request and a no-rewrite request. The block turns these attributes into a 128-bit internal frame header. It sends that header to the queue as four 32-bit words, then passes each payload word on one cycle after it is written.

The frame is closed by an end control write, which carries the number of valid bytes in the last word. If fewer payload words than one 64-byte buffer cell were written, the block adds zero words until the cell is full. It then adds one zero word as a stand-in CRC. That word carries the end marker and the valid-byte count. The count is forced to zero for frames shorter than a cell.

A registered ready output tells software when the next write is accepted. Ready is low whenever the queue reports that it is not ready or that its watermark has been reached, and a start write is refused then. A data write outside an open frame is dropped and sets a sticky error flag.

Top module: `cpu_inj_framer`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_sof`, `out_eof`, `inj_ready` and `proto_err` are 0. One clock after reset is released, `inj_ready` is 1 if `q_fifo_rdy` is 1 and `q_wmark` is 0.
- R2: An accepted start write produces exactly four header words on consecutive cycles, highest header word first, and `out_sof` is set on the first of them only. Header layout: bit 127 is `hdr_bypass`, bits 67:56 are `hdr_dst_mask`, bits 27:20 are zero (CPU queue mask), bit 16 is `hdr_tag_s` (0 = C-tag, 1 = S-tag), bits 11:0 are `hdr_vid`, and all other bits are zero except those named in R3.
- R3: Header bits 29:28 are 3 when `hdr_no_rewrite` was 1 at the start write, and 0 otherwise.
- R4: Each accepted payload word appears on `out_data` with `out_valid` set, in write order, one clock after its write.
- R5: If the end write arrives after fewer than 16 payload words, zero words follow until 16 payload-plus-pad words have been sent.
- R6: After the last payload or pad word comes exactly one zero word, with `out_eof` set, and it is the only word of the frame with `out_eof` set.
- R7: `out_vld_bytes` on the end word equals the end write's `ctl_vld_bytes` when at least 16 payload words were written, and 0 otherwise. The value 0 means that all four bytes are valid.
- R8: `inj_ready` is 0 one clock after `q_fifo_rdy` is 0 or `q_wmark` is 1. A start write while `inj_ready` is 0 produces no output.
- R9: A data write while no frame body is open, whether idle or during header, pad or CRC emission, produces no output and sets `proto_err`. `proto_err` stays at 1 until reset.
- R10: `inj_ready` is 0 while header, pad or CRC words are being emitted, and 1 while the frame body is open.
- R11: A frame of 16 or more payload words gets no pad words. The CRC word follows the last payload word directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_fifo_rdy | input | 1 | Queue can take a frame |
| q_wmark | input | 1 | Queue fill watermark reached |
| ctl_wr | input | 1 | Control write strobe |
| ctl_sof | input | 1 | Control write opens a frame |
| ctl_eof | input | 1 | Control write closes the frame |
| ctl_vld_bytes | input | 2 | Valid bytes in the last word (0 = all four) |
| data_wr | input | 1 | Payload word write strobe |
| data_in | input | 32 | Payload word |
| hdr_dst_mask | input | 12 | Destination port mask, sampled at start |
| hdr_tag_s | input | 1 | Tag kind, 1 = S-tag, sampled at start |
| hdr_vid | input | 12 | VLAN identifier, sampled at start |
| hdr_bypass | input | 1 | Bypass analyzer, sampled at start |
| hdr_no_rewrite | input | 1 | Disable rewriting, sampled at start |
| inj_ready | output | 1 | Next write will be accepted |
| proto_err | output | 1 | Sticky out-of-frame data write flag |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_sof | output | 1 | First header word |
| out_eof | output | 1 | CRC placeholder word ending the frame |
| out_vld_bytes | output | 2 | Valid bytes of last word, on the end word |

## Verification
A word counter that drifts shows up in the output stream within one frame. The frame then has the wrong number of pad words, or the CRC word arrives early or late, and the scoreboard reports this as a mismatch or as an unexpected word in the same frame. A wrong sequencer state shows up at `inj_ready` one clock after the faulty transition, because ready is registered from the next state. A header field placed at the wrong bit position fails the compare on the first frame whose attributes are non-zero. The test frames therefore use asymmetric mask and VID values.

// File: rtl/inj_pkg.sv
`timescale 1ns/1ps
package inj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_BODY = 3'd2,
    ST_PAD  = 3'd3,
    ST_CRC  = 3'd4
  } inj_state_e;

  typedef struct packed {
    logic [31:0] data;
    logic        sof;
    logic        eof;
    logic [1:0]  vld;
  } inj_word_t;

  localparam int HDR_WORDS = 4;
endpackage

// File: rtl/inj_hdr_pack.sv
`timescale 1ns/1ps
module inj_hdr_pack #(
  parameter int DST_W = 12,
  parameter int VID_W = 12,
  parameter logic [7:0] CPUQ_MASK = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [DST_W-1:0] dst_mask,
  input  logic             tag_s,
  input  logic [VID_W-1:0] vid,
  input  logic             bypass,
  input  logic             no_rewrite,
  input  logic [1:0]       word_idx,
  output logic [31:0]      word
);
  import inj_pkg::*;

  logic [DST_W-1:0] mask_q;
  logic [VID_W-1:0] vid_q;
  logic             tag_q, byp_q, norw_q;
  logic [127:0]     hdr;
  logic [31:0]      words [HDR_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      vid_q  <= '0;
      tag_q  <= 1'b0;
      byp_q  <= 1'b0;
      norw_q <= 1'b0;
    end else if (cap_en) begin
      mask_q <= dst_mask;
      vid_q  <= vid;
      tag_q  <= tag_s;
      byp_q  <= bypass;
      norw_q <= no_rewrite;
    end
  end

  always_comb begin
    hdr                  = '0;
    hdr[127]             = byp_q;
    hdr[56 +: DST_W]     = mask_q;
    hdr[29:28]           = {2{norw_q}};
    hdr[27:20]           = CPUQ_MASK;
    hdr[16]              = tag_q;
    hdr[0 +: VID_W]      = vid_q;
  end

  for (genvar i = 0; i < HDR_WORDS; i++) begin : g_word
    assign words[i] = hdr[(HDR_WORDS-1-i)*32 +: 32];
  end

  assign word = words[word_idx];
endmodule

// File: rtl/inj_seq.sv
`timescale 1ns/1ps
module inj_seq #(
  parameter int CELL_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_fifo_rdy,
  input  logic                q_wmark,
  input  logic                ctl_wr,
  input  logic                ctl_sof,
  input  logic                ctl_eof,
  input  logic [1:0]          ctl_vld_bytes,
  input  logic                data_wr,
  input  logic [31:0]         data_in,
  input  logic [31:0]         hdr_word,
  output logic [1:0]          hdr_idx,
  output logic                hdr_cap,
  output logic                nxt_valid,
  output inj_pkg::inj_word_t  nxt_word,
  output logic                ready,
  output logic                proto_err
);
  import inj_pkg::*;

  localparam int CELL_WORDS = CELL_BYTES / 4;
  localparam int CW = $clog2(CELL_WORDS + 1);
  localparam logic [CW-1:0] CELL_N = CW'(CELL_WORDS);

  inj_state_e    st, st_n;
  logic [1:0]    hidx_q, hidx_n;
  logic [CW-1:0] wcnt_q, wcnt_n, cnt_after;
  logic [1:0]    vld_q, vld_n;
  logic          sof_ok, eof_ok, dat_ok, bad_wr, q_ok;

  assign q_ok   = q_fifo_rdy && !q_wmark;
  assign sof_ok = ctl_wr && ctl_sof && (st == ST_IDLE) && ready;
  assign eof_ok = ctl_wr && ctl_eof && (st == ST_BODY);
  assign dat_ok = data_wr && (st == ST_BODY);
  assign bad_wr = data_wr && (st != ST_BODY);
  assign cnt_after = (dat_ok && wcnt_q != CELL_N) ? wcnt_q + 1'b1 : wcnt_q;
  assign hdr_idx = hidx_q;
  assign hdr_cap = sof_ok;

  always_comb begin
    st_n      = st;
    hidx_n    = hidx_q;
    wcnt_n    = wcnt_q;
    vld_n     = vld_q;
    nxt_valid = 1'b0;
    nxt_word  = '0;
    unique case (st)
      ST_IDLE: begin
        if (sof_ok) begin
          st_n   = ST_HDR;
          hidx_n = 2'd0;
          wcnt_n = '0;
          vld_n  = 2'd0;
        end
      end
      ST_HDR: begin
        nxt_valid     = 1'b1;
        nxt_word.data = hdr_word;
        nxt_word.sof  = (hidx_q == 2'd0);
        hidx_n        = hidx_q + 2'd1;
        if (hidx_q == 2'(HDR_WORDS - 1)) st_n = ST_BODY;
      end
      ST_BODY: begin
        if (dat_ok) begin
          nxt_valid     = 1'b1;
          nxt_word.data = data_in;
        end
        wcnt_n = cnt_after;
        if (eof_ok) begin
          if (cnt_after < CELL_N) begin
            vld_n = 2'd0;
            st_n  = ST_PAD;
          end else begin
            vld_n = ctl_vld_bytes;
            st_n  = ST_CRC;
          end
        end
      end
      ST_PAD: begin
        nxt_valid = 1'b1;
        wcnt_n    = wcnt_q + 1'b1;
        if (wcnt_q + 1'b1 >= CELL_N) st_n = ST_CRC;
      end
      ST_CRC: begin
        nxt_valid    = 1'b1;
        nxt_word.eof = 1'b1;
        nxt_word.vld = vld_q;
        st_n         = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hidx_q    <= '0;
      wcnt_q    <= '0;
      vld_q     <= '0;
      ready     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st     <= st_n;
      hidx_q <= hidx_n;
      wcnt_q <= wcnt_n;
      vld_q  <= vld_n;
      ready  <= ((st_n == ST_IDLE) && q_ok) || (st_n == ST_BODY);
      if (bad_wr) proto_err <= 1'b1;
    end
  end

  // R9: error flag never clears outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  // R10: no ready while the block emits its own words
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR || st == ST_PAD || st == ST_CRC) |-> !ready);
  // R5: padding never runs past one cell
  a_r5_pad_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAD) |-> (wcnt_q < CELL_N));
  // R10: body always ready
  a_r10_body_ready: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BODY) |-> ready);
endmodule

// File: rtl/inj_out_reg.sv
`timescale 1ns/1ps
module inj_out_reg (
  input  logic               clk,
  input  logic               rst,
  input  logic               nxt_valid,
  input  inj_pkg::inj_word_t nxt_word,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic               out_sof,
  output logic               out_eof,
  output logic [1:0]         out_vld_bytes
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_sof       <= 1'b0;
      out_eof       <= 1'b0;
      out_vld_bytes <= '0;
    end else begin
      out_valid     <= nxt_valid;
      out_data      <= nxt_valid ? nxt_word.data : 32'd0;
      out_sof       <= nxt_valid && nxt_word.sof;
      out_eof       <= nxt_valid && nxt_word.eof;
      out_vld_bytes <= nxt_valid ? nxt_word.vld : 2'd0;
    end
  end

  // R2: first header word is a valid word and is followed by more header
  a_r2_sof_then_valid: assert property (@(posedge clk) disable iff (rst)
    out_sof |=> (out_valid && !out_sof));
  // R6: the end word is the zero CRC placeholder
  a_r6_eof_zero: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (out_valid && out_data == 32'd0));
  // R2, R6: start and end never on the same word
  a_r6_marks_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_sof, out_eof}));
endmodule

// File: rtl/cpu_inj_framer.sv
`timescale 1ns/1ps
module cpu_inj_framer #(
  parameter int DST_W      = 12,
  parameter int VID_W      = 12,
  parameter int CELL_BYTES = 64,
  parameter logic [7:0] CPUQ_MASK = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_fifo_rdy,
  input  logic             q_wmark,
  input  logic             ctl_wr,
  input  logic             ctl_sof,
  input  logic             ctl_eof,
  input  logic [1:0]       ctl_vld_bytes,
  input  logic             data_wr,
  input  logic [31:0]      data_in,
  input  logic [DST_W-1:0] hdr_dst_mask,
  input  logic             hdr_tag_s,
  input  logic [VID_W-1:0] hdr_vid,
  input  logic             hdr_bypass,
  input  logic             hdr_no_rewrite,
  output logic             inj_ready,
  output logic             proto_err,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [1:0]       out_vld_bytes
);
  import inj_pkg::*;

  logic        hdr_cap, nxt_valid;
  logic [1:0]  hdr_idx;
  logic [31:0] hdr_word;
  inj_word_t   nxt_word;

  inj_hdr_pack #(.DST_W(DST_W), .VID_W(VID_W), .CPUQ_MASK(CPUQ_MASK)) u_hdr (
    .clk(clk), .rst(rst), .cap_en(hdr_cap),
    .dst_mask(hdr_dst_mask), .tag_s(hdr_tag_s), .vid(hdr_vid),
    .bypass(hdr_bypass), .no_rewrite(hdr_no_rewrite),
    .word_idx(hdr_idx), .word(hdr_word)
  );

  inj_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk(clk), .rst(rst), .q_fifo_rdy(q_fifo_rdy), .q_wmark(q_wmark),
    .ctl_wr(ctl_wr), .ctl_sof(ctl_sof), .ctl_eof(ctl_eof),
    .ctl_vld_bytes(ctl_vld_bytes), .data_wr(data_wr), .data_in(data_in),
    .hdr_word(hdr_word), .hdr_idx(hdr_idx), .hdr_cap(hdr_cap),
    .nxt_valid(nxt_valid), .nxt_word(nxt_word),
    .ready(inj_ready), .proto_err(proto_err)
  );

  inj_out_reg u_out (
    .clk(clk), .rst(rst), .nxt_valid(nxt_valid), .nxt_word(nxt_word),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_vld_bytes(out_vld_bytes)
  );

  // R8: a frame only starts from a start write seen while ready
  a_r8_sof_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(out_sof) |-> $past(inj_ready, 2));
endmodule

// File: tb/tb_cpu_inj_framer.sv
`timescale 1ns/1ps
module tb_cpu_inj_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        q_fifo_rdy = 1'b1, q_wmark = 1'b0;
  logic        ctl_wr = 0, ctl_sof = 0, ctl_eof = 0;
  logic [1:0]  ctl_vld_bytes = 0;
  logic        data_wr = 0;
  logic [31:0] data_in = 0;
  logic [11:0] hdr_dst_mask = 0;
  logic        hdr_tag_s = 0;
  logic [11:0] hdr_vid = 0;
  logic        hdr_bypass = 0, hdr_no_rewrite = 0;
  logic        inj_ready, proto_err, out_valid, out_sof, out_eof;
  logic [31:0] out_data;
  logic [1:0]  out_vld_bytes;

  always #2 clk = ~clk;

  cpu_inj_framer dut (
    .clk(clk), .rst(rst), .q_fifo_rdy(q_fifo_rdy), .q_wmark(q_wmark),
    .ctl_wr(ctl_wr), .ctl_sof(ctl_sof), .ctl_eof(ctl_eof),
    .ctl_vld_bytes(ctl_vld_bytes), .data_wr(data_wr), .data_in(data_in),
    .hdr_dst_mask(hdr_dst_mask), .hdr_tag_s(hdr_tag_s), .hdr_vid(hdr_vid),
    .hdr_bypass(hdr_bypass), .hdr_no_rewrite(hdr_no_rewrite),
    .inj_ready(inj_ready), .proto_err(proto_err), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_vld_bytes(out_vld_bytes)
  );

  typedef struct packed {
    logic [31:0] data;
    logic        sof;
    logic        eof;
    logic [1:0]  vld;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, unexp = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input bit s, input bit e, input logic [1:0] v, input string tag);
    exp_q.push_back({d, s, e, v});
    tag_q.push_back(tag);
  endtask

  // monitor: compares every produced word with the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        unexp++;
        chk(0, "R8/R9 unexpected word", {30'd0, out_data, out_sof, out_eof}, 64'd0);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_data, out_sof, out_eof, out_vld_bytes} == e, t,
            {28'd0, out_data, out_sof, out_eof, out_vld_bytes}, {28'd0, e});
      end
    end
  end

  task automatic wait_ready();
    while (!inj_ready) @(negedge clk);
  endtask

  task automatic send_frame(input logic [11:0] mask, input bit tg, input logic [11:0] vid,
                            input bit byp, input bit norw, input int n,
                            input logic [1:0] vld, input bit stray);
    logic [31:0] w3;
    wait_ready();
    w3 = {2'b00, {2{norw}}, 8'h00, 3'b000, tg, 4'h0, vid};
    push({byp, 31'd0}, 1, 0, 0, "R2 hdr word0");
    push({20'd0, mask[11:8]}, 0, 0, 0, "R2 hdr word1");
    push({mask[7:0], 24'd0}, 0, 0, 0, "R2 hdr word2");
    push(w3, 0, 0, 0, "R2/R3 hdr word3");
    hdr_dst_mask = mask; hdr_tag_s = tg; hdr_vid = vid;
    hdr_bypass = byp; hdr_no_rewrite = norw;
    ctl_wr = 1; ctl_sof = 1;
    @(negedge clk);
    ctl_wr = 0; ctl_sof = 0;
    chk(!inj_ready, "R10 ready low in header", {63'd0, inj_ready}, 64'd0);
    if (stray) begin
      data_wr = 1; data_in = 32'hDEAD_BEEF;
      @(negedge clk);
      data_wr = 0;
    end
    for (int i = 0; i < n; i++) begin
      wait_ready();
      chk(inj_ready, "R10 ready high in body", {63'd0, inj_ready}, 64'd1);
      data_wr = 1; data_in = {mask[7:0], vid[7:0], 16'(i)};
      push(data_in, 0, 0, 0, "R4 payload");
      if (i == n - 1) begin
        ctl_wr = 1; ctl_eof = 1; ctl_vld_bytes = vld;
      end
      @(negedge clk);
      data_wr = 0; ctl_wr = 0; ctl_eof = 0;
    end
    if (n == 0) begin
      wait_ready();
      ctl_wr = 1; ctl_eof = 1; ctl_vld_bytes = vld;
      @(negedge clk);
      ctl_wr = 0; ctl_eof = 0;
    end
    for (int i = n; i < 16; i++) push(32'd0, 0, 0, 0, "R5 pad word");
    push(32'd0, 0, 1, (n >= 16) ? vld : 2'd0, "R6/R7/R11 crc word");
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all words seen", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sof && !out_eof, "R1 outputs idle in reset",
        {61'd0, out_valid, out_sof, out_eof}, 64'd0);
    chk(!inj_ready && !proto_err, "R1 ready/err low in reset",
        {62'd0, inj_ready, proto_err}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(inj_ready, "R1 ready after reset", {63'd0, inj_ready}, 64'd1);
  endtask

  initial begin
    int u0;
    @(negedge clk);
    do_reset();

    // short frame with bypass: padding, vld forced to 0
    send_frame(12'hA5C, 0, 12'h123, 1, 0, 5, 2'd2, 0);
    drain();
    // exact cell, S-tag, no-rewrite: no pad, vld kept
    send_frame(12'h001, 1, 12'hFFF, 0, 1, 16, 2'd1, 0);
    drain();
    // long frame
    send_frame(12'hFFF, 0, 12'h801, 0, 0, 20, 2'd3, 0);
    drain();
    // empty frame: full cell of pad
    send_frame(12'h3C0, 1, 12'h00A, 1, 1, 0, 2'd3, 0);
    drain();

    // R8 watermark
    q_wmark = 1;
    @(negedge clk); @(negedge clk);
    chk(!inj_ready, "R8 ready low on watermark", {63'd0, inj_ready}, 64'd0);
    u0 = unexp;
    ctl_wr = 1; ctl_sof = 1; @(negedge clk); ctl_wr = 0; ctl_sof = 0;
    repeat (8) @(negedge clk);
    chk(unexp == u0, "R8 refused start has no output", 64'(unexp), 64'(u0));
    q_wmark = 0; q_fifo_rdy = 0;
    @(negedge clk); @(negedge clk);
    chk(!inj_ready, "R8 ready low when fifo not ready", {63'd0, inj_ready}, 64'd0);
    ctl_wr = 1; ctl_sof = 1; @(negedge clk); ctl_wr = 0; ctl_sof = 0;
    repeat (8) @(negedge clk);
    chk(unexp == u0, "R8 refused start no output (fifo)", 64'(unexp), 64'(u0));
    q_fifo_rdy = 1;
    @(negedge clk); @(negedge clk);
    chk(inj_ready, "R8 ready back", {63'd0, inj_ready}, 64'd1);

    // R9 stray data in idle
    chk(!proto_err, "R9 no error yet", {63'd0, proto_err}, 64'd0);
    data_wr = 1; data_in = 32'h1234_5678; @(negedge clk); data_wr = 0;
    chk(proto_err, "R9 error set on idle data", {63'd0, proto_err}, 64'd1);
    repeat (4) @(negedge clk);
    chk(unexp == u0, "R9 idle data dropped", 64'(unexp), 64'(u0));
    // stray data during header is dropped too, flag stays
    send_frame(12'h5A5, 1, 12'h456, 0, 0, 3, 2'd1, 1);
    drain();
    chk(proto_err, "R9 error sticky", {63'd0, proto_err}, 64'd1);
    do_reset();
    chk(!proto_err, "R9 error cleared by reset", {63'd0, proto_err}, 64'd0);
    send_frame(12'h00F, 0, 12'h0F0, 0, 1, 17, 2'd2, 0);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule